// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block watches the raw fault comparators of a six-switch output stage, built as three half-bridges, and decides which switches must be held off. Its inputs are a supply undervoltage flag, one overtemperature flag and one overcurrent flag per switch, a thermal prewarning flag and per-switch open-load flags. From these it produces three summary flags and a six-bit per-switch status field. The flags are a temperature warning, an overload flag and a supply-fail flag. It also drives six disable lines that the output stage combines with its own on/off commands.

Each kind of fault recovers in its own way. An undervoltage must persist for a qualification window before it forces every switch off. The switches return as soon as the supply recovers, but the supply-fail flag stays set. Overtemperature and qualified overcurrent each latch a shutdown on the affected switch only. A status-reset command from the host control word clears these latches, and an overtemperature latch clears only once its switch has cooled. Overcurrent shutdown can be turned off entirely with an enable bit. The command arrives as a one-cycle execute strobe together with the reset bit.

Top module: `fault_supervisor`

## Requirements
- R1: An undervoltage forces all six `sw_disable` bits high once `uv_raw` has been high on UV_QUAL consecutive rising clock edges. A shorter pulse has no effect, and any low cycle restarts the count.
- R2: `psf` goes high one edge after the undervoltage qualifies. `sw_disable` drops one edge after `uv_raw` falls, while `psf` stays high until a reset command (`cmd_exec` and `srr` both high at an edge) arrives with no qualified undervoltage.
- R3: An `ot_raw[i]` high at an edge sets `sw_disable[i]` and `ovl` at that edge. The shutdown is kept after `ot_raw[i]` falls, and is released only by a reset command given while `ot_raw[i]` is low.
- R4: `tp` equals the value `pw_raw` had at the previous edge and is never latched.
- R5: With `ocs_en` high, `oc_raw[i]` high on OC_QUAL consecutive edges sets `sw_disable[i]` and `ovl` at the last of them. A shorter pulse has no effect. With `ocs_en` low, overcurrent never sets `ovl` or any disable bit.
- R6: A reset command clears `ovl`, `psf` and the overcurrent shutdowns at that edge, unless a new fault of the same kind is being set at the same edge, in which case setting wins.
- R7: A switch whose `sw_on` bit is 1 and that is not disabled reports 1 in `sw_status`. A switch that is on but disabled reports 0.
- R8: With `ol_det_n` low, a switch whose `sw_on` bit is 0 reports `ol_raw[i]` in `sw_status[i]`. With `ol_det_n` high, an off switch reports 0. The reset command does not clear this report.
- R9: After reset `tp`, `ovl`, `psf`, `sw_status` and `sw_disable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_raw | input | 1 | Raw supply undervoltage comparator |
| ot_raw | input | NSW | Per-switch overtemperature comparator, high above shutdown, low once cooled below restart |
| pw_raw | input | 1 | Thermal prewarning comparator (hysteresis external) |
| oc_raw | input | NSW | Per-switch overcurrent comparator |
| ol_raw | input | NSW | Per-switch open-load comparator |
| cmd_exec | input | 1 | One-cycle strobe: control word executed |
| srr | input | 1 | Status-reset bit of the control word |
| ocs_en | input | 1 | Overcurrent shutdown enable |
| ol_det_n | input | 1 | Open-load detection enable, active low |
| sw_on | input | NSW | Commanded on state per switch |
| tp | output | 1 | Temperature prewarning flag |
| ovl | output | 1 | Latched overload flag |
| psf | output | 1 | Latched supply-fail flag |
| sw_status | output | NSW | Per-switch status |
| sw_disable | output | NSW | Per-switch forced-off lines |

## Verification
The assertions assume that every input is synchronous to `clk` and that `cmd_exec` is a single-cycle strobe. They also assume `ot_raw` is already free of chatter, because any edge on which it is high latches a shutdown. The bench changes inputs only on falling edges and holds each raw fault for an exact number of edges, one fewer than or equal to the qualification window. It then samples half a cycle after the edge of interest, so every count boundary is hit without ambiguity.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NSW     = 6,
  parameter int UV_QUAL = 16,
  parameter int OC_QUAL = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uv_raw,
  input  logic [NSW-1:0] ot_raw,
  input  logic           pw_raw,
  input  logic [NSW-1:0] oc_raw,
  input  logic [NSW-1:0] ol_raw,
  input  logic           cmd_exec,
  input  logic           srr,
  input  logic           ocs_en,
  input  logic           ol_det_n,
  input  logic [NSW-1:0] sw_on,
  output logic           tp,
  output logic           ovl,
  output logic           psf,
  output logic [NSW-1:0] sw_status,
  output logic [NSW-1:0] sw_disable
);
  localparam int UVW = $clog2(UV_QUAL + 1);
  localparam int OCW = $clog2(OC_QUAL + 1);

  logic [UVW-1:0] uv_cnt;
  logic           uv_q;
  logic [NSW-1:0] ot_lat, oc_lat, oc_hit;
  logic           clr;

  assign clr  = cmd_exec & srr;
  assign uv_q = (uv_cnt == UVW'(UV_QUAL));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       uv_cnt <= '0;
    else if (!uv_raw) uv_cnt <= '0;
    else if (!uv_q)   uv_cnt <= uv_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    psf <= 1'b0;
    else if (uv_q) psf <= 1'b1;
    else if (clr)  psf <= 1'b0;

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    logic [OCW-1:0] oc_cnt;
    logic           oc_act;
    assign oc_act    = oc_raw[i] & ocs_en;
    assign oc_hit[i] = oc_act & (oc_cnt >= OCW'(OC_QUAL - 1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        oc_cnt <= '0;
      else if (!oc_act)                  oc_cnt <= '0;
      else if (oc_cnt < OCW'(OC_QUAL))   oc_cnt <= oc_cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         oc_lat[i] <= 1'b0;
      else if (oc_hit[i]) oc_lat[i] <= 1'b1;
      else if (clr)       oc_lat[i] <= 1'b0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         ot_lat[i] <= 1'b0;
      else if (ot_raw[i]) ot_lat[i] <= 1'b1;
      else if (clr)       ot_lat[i] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ovl <= 1'b0;
    else if (|ot_raw || |oc_hit)    ovl <= 1'b1;
    else if (clr)                   ovl <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tp <= 1'b0;
    else        tp <= pw_raw;

  assign sw_disable = {NSW{uv_q}} | ot_lat | oc_lat;
  assign sw_status  = (sw_on & ~sw_disable) | (~sw_on & ol_raw & {NSW{~ol_det_n}});
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int NSW     = 6,
  parameter int UV_QUAL = 16,
  parameter int OC_QUAL = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           uv_raw,
  input logic [NSW-1:0] ot_raw,
  input logic           pw_raw,
  input logic [NSW-1:0] oc_raw,
  input logic [NSW-1:0] ol_raw,
  input logic           cmd_exec,
  input logic           srr,
  input logic           ocs_en,
  input logic           ol_det_n,
  input logic [NSW-1:0] sw_on,
  input logic           tp,
  input logic           ovl,
  input logic           psf,
  input logic [NSW-1:0] sw_status,
  input logic [NSW-1:0] sw_disable
);
  int unsigned uv_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 uv_run <= 0;
    else if (!uv_raw)           uv_run <= 0;
    else if (uv_run < UV_QUAL)  uv_run <= uv_run + 1;

  p_uv_all_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_run == UV_QUAL) |-> (sw_disable == {NSW{1'b1}}));

  p_psf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psf && !(cmd_exec && srr)) |=> psf);

  p_ot_shutdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ot_raw) |=> (ovl && ((sw_disable & $past(ot_raw)) == $past(ot_raw))));

  p_tp_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pw_raw) |=> tp);

  p_oc_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ocs_en && !ovl && ot_raw == '0) |=> !ovl);

  p_srr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && srr && ot_raw == '0 && !ocs_en && uv_run != UV_QUAL) |=> (!ovl && !psf));

  p_on_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_status & sw_on & ~sw_disable) == (sw_on & ~sw_disable)));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NSW(NSW), .UV_QUAL(UV_QUAL), .OC_QUAL(OC_QUAL)) u_chk (.*);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int NSW = 6, UVQ = 16, OCQ = 12;

  logic clk = 0, rst_n = 0;
  logic uv_raw = 0, pw_raw = 0, cmd_exec = 0, srr = 0, ocs_en = 0, ol_det_n = 1;
  logic [NSW-1:0] ot_raw = '0, oc_raw = '0, ol_raw = '0, sw_on = '0;
  logic tp, ovl, psf;
  logic [NSW-1:0] sw_status, sw_disable;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.NSW(NSW), .UV_QUAL(UVQ), .OC_QUAL(OCQ)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_cmd();
    cmd_exec = 1; srr = 1; step(1); cmd_exec = 0; srr = 0;
  endtask

  task automatic t_reset();
    chk("R9 tp", tp, 0); chk("R9 ovl", ovl, 0); chk("R9 psf", psf, 0);
    chk("R9 status", sw_status, 0); chk("R9 disable", sw_disable, 0);
  endtask

  task automatic t_status();
    sw_on = 6'b101010; step(1);
    chk("R7 on status", sw_status, 6'b101010);
    sw_on = 6'b010101; step(1);
    chk("R7 on status b", sw_status, 6'b010101);
  endtask

  task automatic t_uv();
    uv_raw = 1; step(UVQ - 1);
    chk("R1 short uv", sw_disable, 0);
    uv_raw = 0; step(1); uv_raw = 1; step(UVQ - 1);
    chk("R1 restart count", sw_disable, 0);
    chk("R2 no psf yet", psf, 0);
    step(1);
    chk("R1 all off", sw_disable, 6'h3F);
    chk("R7 disabled on reads 0", sw_status, 0);
    step(1);
    chk("R2 psf set", psf, 1);
    uv_raw = 0; step(1);
    chk("R2 outputs back", sw_disable, 0);
    chk("R2 psf held", psf, 1);
    step(3);
    chk("R2 psf still held", psf, 1);
    reset_cmd();
    chk("R6 psf cleared", psf, 0);
  endtask

  task automatic t_ot();
    sw_on = 6'b000100; ot_raw = 6'b000100; step(1);
    chk("R3 ot disable", sw_disable, 6'b000100);
    chk("R3 ovl", ovl, 1);
    chk("R3 status off", sw_status, 0);
    reset_cmd();
    chk("R3 hot srr keeps", sw_disable, 6'b000100);
    ot_raw = 0; step(2);
    chk("R3 latched after cool", sw_disable, 6'b000100);
    reset_cmd();
    chk("R3 released", sw_disable, 0);
    chk("R6 ovl cleared", ovl, 0);
    chk("R7 status back", sw_status, 6'b000100);
  endtask

  task automatic t_tp();
    pw_raw = 1; step(1); chk("R4 tp high", tp, 1);
    pw_raw = 0; step(1); chk("R4 tp low not latched", tp, 0);
  endtask

  task automatic t_oc();
    sw_on = 6'b001000; ocs_en = 0; oc_raw = 6'b001000; step(3 * OCQ);
    chk("R5 gated ovl", ovl, 0);
    chk("R5 gated disable", sw_disable, 0);
    ocs_en = 1; step(OCQ - 1);
    chk("R5 below window", sw_disable, 0);
    chk("R5 below window ovl", ovl, 0);
    step(1);
    chk("R5 oc disable", sw_disable, 6'b001000);
    chk("R5 oc ovl", ovl, 1);
    oc_raw = 0; step(2);
    chk("R5 oc latched", sw_disable, 6'b001000);
    reset_cmd();
    chk("R6 oc released", sw_disable, 0);
    chk("R6 ovl cleared oc", ovl, 0);
    ocs_en = 0;
  endtask

  task automatic t_ol();
    sw_on = 6'b000010; ol_raw = 6'b000011; ol_det_n = 0; step(1);
    chk("R8 open load off sw", sw_status, 6'b000011);
    reset_cmd();
    chk("R8 srr keeps open load", sw_status, 6'b000011);
    ol_det_n = 1; step(1);
    chk("R8 detection off", sw_status, 6'b000010);
    ol_raw = 0; sw_on = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1; step(1);
    t_reset();
    t_status();
    t_uv();
    t_ot();
    t_tp();
    t_oc();
    t_ol();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule